// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Registers

This block holds the interrupt status and interrupt mask state of an SD host controller. Single-cycle event pulses from the command path, the data path and card-detect logic are caught as sticky flags in two status words. Two level inputs that report buffer readiness are turned into sticky flags on their rising edge only. Three live signals (card present, the DAT0 line and command busy) are shown in the status words as they are, without being stored.

Software reads and writes the four words over a simple 32-bit register bus with a two-bit word index. A write to a status word clears each sticky flag whose data bit is 0 and leaves each flag whose data bit is 1. Each mask word holds one mask bit per status bit position. The single interrupt output is high while any sticky flag is set and its mask bit is 0.

Top module: `sdh_irq_regs`

## Requirements
- R1: After reset every sticky flag is 0, both mask words read 0x0000FFFF and `irq` is 0.
- R2: A pulse on `ev_resp_done`, `ev_data_done`, `ev_card_out` or `ev_card_in` sets bit 0, 2, 3 or 4 of status word 1 (index 0). The bit reads 1 from the cycle after the pulse and stays set until it is cleared.
- R3: Status word 1 bit 5 follows `card_present`. Status word 2 bit 7 follows `dat0_level` and bit 14 follows `cmd_busy`. These live bits are not stored, and writes have no effect on them.
- R4: A pulse on `err_in[k]` sets status word 2 (index 1) bit k for k = 0..6 (command index, CRC, end bit, data timeout, illegal write, illegal read, response timeout). A pulse on `err_in[7]` (illegal access) sets bit 15.
- R5: Status word 2 bit 8 sets on a rising edge of `rbuf_ready` and bit 9 sets on a rising edge of `wbuf_ready`. If such a flag is cleared while its level input stays high, it stays 0 until the next rising edge.
- R6: A write to a status word clears each sticky bit whose write-data bit is 0 and keeps each sticky bit whose write-data bit is 1.
- R7: An event that arrives in the same cycle as a write that clears its flag leaves the flag set.
- R8: Mask word 1 is at index 2 and mask word 2 is at index 3. Each holds write-data bits 15:0, and bits 31:16 read 0.
- R9: `irq` is high exactly when a sticky flag is set and its mask bit (same word, same position) is 0. Live bits never raise `irq`.
- R10: Status bits that have no function read 0, and writes do not set them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Register write strobe |
| addr | input | 2 | Word index: 0 status 1, 1 status 2, 2 mask 1, 3 mask 2 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ev_resp_done | input | 1 | Response complete pulse |
| ev_data_done | input | 1 | Data complete pulse |
| ev_card_out | input | 1 | Card removed pulse |
| ev_card_in | input | 1 | Card inserted pulse |
| err_in | input | 8 | Error pulses: 0 index, 1 CRC, 2 end bit, 3 data timeout, 4 illegal write, 5 illegal read, 6 response timeout, 7 illegal access |
| rbuf_ready | input | 1 | Read buffer ready level |
| wbuf_ready | input | 1 | Write buffer ready level |
| card_present | input | 1 | Live card-detect level |
| dat0_level | input | 1 | Live DAT0 line level |
| cmd_busy | input | 1 | Live command-busy level |
| irq | output | 1 | Combined interrupt |

## Verification
The bound checker checks the following on every cycle:
- an event pulse sets its flag;
- a buffer flag rises only after its level input was high;
- a clearing write clears a flag unless an event arrives in the same cycle;
- a flag with no write holds its value;
- a mask write is captured;
- `irq` is quiet while all mask bits are 1.

Only the bench scenarios can show the following:
- the exact bit placement of every event and every error input;
- the live bits passing through and ignoring writes;
- a buffer flag staying clear while its level input stays high;
- reads of the unused and upper bits;
- `irq` following individual mask bits.

// File: rtl/sdh_irq_regs.sv
module sdh_irq_regs #(
  parameter int          DW       = 32,
  parameter int          SW       = 16,
  parameter logic [15:0] MASK_RST = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ev_resp_done,
  input  logic          ev_data_done,
  input  logic          ev_card_out,
  input  logic          ev_card_in,
  input  logic [7:0]    err_in,
  input  logic          rbuf_ready,
  input  logic          wbuf_ready,
  input  logic          card_present,
  input  logic          dat0_level,
  input  logic          cmd_busy,
  output logic          irq
);
  localparam logic [SW-1:0] ST1_STICKY = SW'(16'h001D);
  localparam logic [SW-1:0] ST2_STICKY = SW'(16'h837F);

  logic [SW-1:0] st1_q, st2_q, msk1_q, msk2_q;
  logic [SW-1:0] st1_set, st2_set, st1_rd, st2_rd;
  logic          rbuf_q, wbuf_q;
  logic          wr_st1, wr_st2, unused_hi;

  assign unused_hi = ^wdata[DW-1:SW];
  assign wr_st1    = we && (addr == 2'd0);
  assign wr_st2    = we && (addr == 2'd1);

  assign st1_set = SW'({ev_card_in, ev_card_out, ev_data_done, 1'b0, ev_resp_done});
  assign st2_set = SW'({err_in[7], 5'b0, wbuf_ready & ~wbuf_q, rbuf_ready & ~rbuf_q,
                        1'b0, err_in[6:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q  <= '0;
      st2_q  <= '0;
      msk1_q <= MASK_RST[SW-1:0];
      msk2_q <= MASK_RST[SW-1:0];
      rbuf_q <= 1'b0;
      wbuf_q <= 1'b0;
    end else begin
      rbuf_q <= rbuf_ready;
      wbuf_q <= wbuf_ready;
      st1_q  <= ((wr_st1 ? (st1_q & wdata[SW-1:0]) : st1_q) | st1_set) & ST1_STICKY;
      st2_q  <= ((wr_st2 ? (st2_q & wdata[SW-1:0]) : st2_q) | st2_set) & ST2_STICKY;
      if (we && addr == 2'd2) msk1_q <= wdata[SW-1:0];
      if (we && addr == 2'd3) msk2_q <= wdata[SW-1:0];
    end
  end

  assign st1_rd = st1_q | SW'({card_present, 5'b0});
  assign st2_rd = st2_q | SW'({cmd_busy, 6'b0, dat0_level, 7'b0});

  always_comb begin
    case (addr)
      2'd0:    rdata = DW'(st1_rd);
      2'd1:    rdata = DW'(st2_rd);
      2'd2:    rdata = DW'(msk1_q);
      default: rdata = DW'(msk2_q);
    endcase
  end

  assign irq = |(st1_q & ~msk1_q) | |(st2_q & ~msk2_q);
endmodule

// File: rtl/sdh_irq_regs_chk.sv
module sdh_irq_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        we,
  input logic [1:0]  addr,
  input logic [31:0] wdata,
  input logic        ev_resp_done,
  input logic [7:0]  err_in,
  input logic        rbuf_ready,
  input logic [15:0] st1_q,
  input logic [15:0] st2_q,
  input logic [15:0] msk1_q,
  input logic [15:0] msk2_q,
  input logic        irq
);
  p_resp_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resp_done |=> st1_q[0]);

  p_ila_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_in[7] |=> st2_q[15]);

  p_rbuf_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st2_q[8]) |-> $past(rbuf_ready));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd0 && !wdata[0] && !ev_resp_done) |=> !st1_q[0]);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st1_q[0] && !(we && addr == 2'd0)) |=> st1_q[0]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd1 && err_in[0]) |=> st2_q[0]);

  p_mask_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd2) |=> msk1_q == $past(wdata[15:0]));

  p_all_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msk1_q == 16'hFFFF && msk2_q == 16'hFFFF) |-> !irq);
endmodule

bind sdh_irq_regs sdh_irq_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
  .ev_resp_done(ev_resp_done), .err_in(err_in), .rbuf_ready(rbuf_ready),
  .st1_q(st1_q), .st2_q(st2_q), .msk1_q(msk1_q), .msk2_q(msk2_q), .irq(irq)
);

// File: tb/sim_sdh_irq_regs.sv
`timescale 1ns/1ps
module sim_sdh_irq_regs;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        ev_resp_done = 0, ev_data_done = 0, ev_card_out = 0, ev_card_in = 0;
  logic [7:0]  err_in = '0;
  logic        rbuf_ready = 0, wbuf_ready = 0, card_present = 0, dat0_level = 0, cmd_busy = 0;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sdh_irq_regs u0 (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ev_resp_done(ev_resp_done), .ev_data_done(ev_data_done),
    .ev_card_out(ev_card_out), .ev_card_in(ev_card_in), .err_in(err_in),
    .rbuf_ready(rbuf_ready), .wbuf_ready(wbuf_ready), .card_present(card_present),
    .dat0_level(dat0_level), .cmd_busy(cmd_busy), .irq(irq)
  );

  // {events {in,out,data,resp}, err_in, expected status1, expected status2}
  localparam logic [43:0] VEC [10] = '{
    {4'b0001, 8'h00, 16'h0001, 16'h0000},
    {4'b0010, 8'h00, 16'h0004, 16'h0000},
    {4'b0100, 8'h00, 16'h0008, 16'h0000},
    {4'b1000, 8'h00, 16'h0010, 16'h0000},
    {4'b1111, 8'h00, 16'h001D, 16'h0000},
    {4'b0000, 8'h01, 16'h0000, 16'h0001},
    {4'b0000, 8'h40, 16'h0000, 16'h0040},
    {4'b0000, 8'h80, 16'h0000, 16'h8000},
    {4'b0000, 8'h7F, 16'h0000, 16'h007F},
    {4'b0101, 8'h12, 16'h0009, 16'h0012}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic fire(input logic [3:0] ev, input logic [7:0] er);
    @(negedge clk);
    {ev_card_in, ev_card_out, ev_data_done, ev_resp_done} = ev;
    err_in = er;
    @(negedge clk);
    {ev_card_in, ev_card_out, ev_data_done, ev_resp_done} = '0;
    err_in = '0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 st1", 2'd0, 32'h0);
    rd("R1 st2", 2'd1, 32'h0);
    rd("R1 msk1", 2'd2, 32'h0000FFFF);
    rd("R1 msk2", 2'd3, 32'h0000FFFF);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 / R4 table of event patterns
    foreach (VEC[i]) begin
      fire(VEC[i][43:40], VEC[i][39:32]);
      rd("R2 table st1", 2'd0, {16'h0, VEC[i][31:16]});
      rd("R4 table st2", 2'd1, {16'h0, VEC[i][15:0]});
      wr(2'd0, 32'h0);
      wr(2'd1, 32'h0);
    end

    // R3 live bits, R10 unused bits, R9 live bits never interrupt
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h0);
    @(negedge clk);
    card_present = 1; dat0_level = 1; cmd_busy = 1;
    rd("R3 live st1", 2'd0, 32'h00000020);
    rd("R3 live st2", 2'd1, 32'h00004080);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'hFFFFFFFF);
    rd("R3 live st1 after write", 2'd0, 32'h00000020);
    rd("R10 st2 write ones sets nothing", 2'd1, 32'h00004080);
    check("R9 live no irq", {31'b0, irq}, 32'h0);
    card_present = 0; dat0_level = 0; cmd_busy = 0;
    rd("R3 live follow low", 2'd1, 32'h0);
    wr(2'd0, 32'hFFFFFFFF);
    rd("R10 st1 write ones sets nothing", 2'd0, 32'h0);
    wr(2'd2, 32'hFFFF);
    wr(2'd3, 32'hFFFF);

    // R5 buffer ready edges
    @(negedge clk); rbuf_ready = 1;
    @(negedge clk);
    rd("R5 rbuf set", 2'd1, 32'h00000100);
    wr(2'd1, 32'h0);
    repeat (3) @(negedge clk);
    rd("R5 rbuf stays clear while high", 2'd1, 32'h0);
    rbuf_ready = 0;
    @(negedge clk); rbuf_ready = 1;
    @(negedge clk);
    rd("R5 rbuf new edge", 2'd1, 32'h00000100);
    rbuf_ready = 0; wbuf_ready = 1;
    @(negedge clk);
    rd("R5 wbuf set", 2'd1, 32'h00000300);
    wr(2'd1, 32'hFFFFFEFF);
    rd("R5 wbuf kept rbuf cleared", 2'd1, 32'h00000200);
    wbuf_ready = 0;
    wr(2'd1, 32'h0);

    // R6 selective clear
    fire(4'b0011, 8'h0);
    wr(2'd0, 32'hFFFFFFFB);
    rd("R6 selective clear", 2'd0, 32'h00000001);
    wr(2'd0, 32'h0);
    rd("R6 clear all", 2'd0, 32'h0);

    // R7 event beats clear
    @(negedge clk);
    we = 1; addr = 2'd0; wdata = 32'h0; ev_resp_done = 1;
    @(negedge clk);
    we = 0; ev_resp_done = 0;
    rd("R7 set wins over clear", 2'd0, 32'h00000001);

    // R8 mask registers
    wr(2'd2, 32'hA5A51234);
    rd("R8 msk1 low half", 2'd2, 32'h00001234);
    wr(2'd3, 32'h00008000);
    rd("R8 msk2", 2'd3, 32'h00008000);

    // R9 interrupt combining (status1 bit0 is set)
    wr(2'd2, 32'hFFFF);
    wr(2'd3, 32'hFFFF);
    check("R9 masked no irq", {31'b0, irq}, 32'h0);
    wr(2'd2, 32'hFFFE);
    check("R9 unmasked irq", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'hFFFF);
    wr(2'd0, 32'h0);
    fire(4'b0000, 8'h80);
    wr(2'd3, 32'h7FFF);
    check("R9 st2 bit15 irq", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'h0);
    check("R9 irq drops after clear", {31'b0, irq}, 32'h0);

    summary();
  end
endmodule